// File: doc/BRIEF.md
# Byte Execute Unit with Status Flags

This block is the execute stage of a small 8-bit accumulator machine that uses a 14-bit instruction word. Each cycle it takes the current instruction, the value read from the addressed file register and its own working register W, and it produces a result byte. Two write strobes route that byte either into W or back to the file register. It also computes new carry (C), nibble carry (DC) and zero (Z) flags. Every opcode updates its own fixed subset of these flags and leaves the others alone.

The datapath is combinational from inputs to `result`, `wr_w`, `wr_file` and `skip_zero`. W and the three flags are held in registers inside the block. They change only on a clock edge where `exec_en` is high, so a sequencer can present an instruction for several cycles and commit it once. The instruction fetch, the program counter, the file register storage and its addressing are all handled outside this block. The 7-bit file address field is ignored here.

Top module: `byte_alu_exec`

## Requirements
- R1: While `rst_n` is low, and after it rises, W is 0x00 and C, DC and Z are 0.
- R2: Byte operations have the form `00 oooo d fffffff`, with d at instruction bit 7. When d=0, `wr_w` is high and `wr_file` is low. When d=1, `wr_file` is high, `wr_w` is low and W keeps its value. The two strobes are never high together.
- R3: ADDWF (`00 0111`) and ADDLW (`11 111x`, literal k in bits 7:0) give operand + W. C is the carry out of bit 7, DC is the carry out of bit 3, and Z is set when the result is zero.
- R4: SUBWF (`00 0010`) gives f − W and SUBLW (`11 110x`) gives k − W. C=1 when the operand is at least W (no borrow), DC=1 when the low nibble of the operand is at least the low nibble of W, and Z is set when the result is zero.
- R5: ANDWF (`0101`), IORWF (`0100`), XORWF (`0110`), COMF (`1001`), MOVF (`1000`), INCF (`1010`) and DECF (`0011`) in byte form, and ANDLW (`11 1001`), IORLW (`11 1000`) and XORLW (`11 1010`), update Z only. C and DC are held.
- R6: RLF (`00 1101`) gives {f[6:0], C} with new C = f[7]. RRF (`00 1100`) gives {C, f[7:1]} with new C = f[0]. Neither changes DC or Z.
- R7: SWAPF (`00 1110`) exchanges the two nibbles of f. MOVWF (`00 0000 1fffffff`) puts W on `result` with `wr_file` high. MOVLW (`11 00xx`) loads k into W. None of the three changes any flag.
- R8: CLRF (`00 0001 1fffffff`) and CLRW (`00 0001 0xxxxxxx`) produce 0x00 for the file register or for W respectively, and set Z. C and DC are held.
- R9: Bit operations have the form `01 oo bbb fffffff`, with b at bits 9:7. BCF (`oo=00`) clears bit b of f and BSF (`oo=01`) sets it. The result always goes to the file register, and no flag changes.
- R10: INCFSZ (`00 1111`) and DECFSZ (`00 1011`) produce f+1 and f−1, route the result by d, and change no flag. `skip_zero` is high exactly when one of them is presented and its result is 0x00.
- R11: W and the flags change only on a clock edge where `exec_en` is high. With `exec_en` low they hold their values whatever the instruction is.
- R12: Every encoding outside the supported set leaves both strobes low, and W and the flags unchanged even when `exec_en` is high. This covers class `10`, the bit tests (`01 1x`), `11 01xx`, `11 1011`, and `00 0000` with d=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| exec_en | input | 1 | Commit strobe for W and flag updates |
| instr | input | 14 | Instruction word |
| freg_in | input | 8 | Value of the addressed file register |
| result | output | 8 | Result byte of the presented instruction |
| wr_w | output | 1 | Result is destined for W |
| wr_file | output | 1 | Result is destined for the file register |
| skip_zero | output | 1 | Increment/decrement-and-test result is zero |
| w_q | output | 8 | Working register W |
| c_q | output | 1 | Carry flag |
| dc_q | output | 1 | Nibble carry flag |
| z_q | output | 1 | Zero flag |

## Verification
Some properties are checked by assertions on every cycle:
- the two destination strobes are exclusive;
- W follows `result` exactly when a W-bound instruction is committed;
- the flags freeze whenever `exec_en` is low;
- RLF's new carry comes from operand bit 7;
- SWAPF leaves all flags intact;
- bit operations always target the file register;
- `skip_zero` implies a zero result.

Other behaviour only the bench's scenarios can show. This includes the exact carry and nibble-carry values across add and subtract boundaries, the inverted-borrow convention, and the rotate value with a carry fed in. It also includes the full per-opcode flag masks and the silent behaviour of unsupported encodings. The bench covers these by comparing against its own model over directed corners and random instruction words.

// File: rtl/byte_alu_pkg.sv
package byte_alu_pkg;

   localparam int BYTE_W    = 8;
   localparam int BIT_IDX_W = $clog2(BYTE_W);

   // instruction classes (two top bits)
   localparam logic [1:0] CLS_BYTE = 2'b00;
   localparam logic [1:0] CLS_BIT  = 2'b01;
   localparam logic [1:0] CLS_LIT  = 2'b11;

   // byte-class operation nibble
   localparam logic [3:0] BOP_MOVE_W = 4'h0;
   localparam logic [3:0] BOP_CLEAR  = 4'h1;
   localparam logic [3:0] BOP_SUB    = 4'h2;
   localparam logic [3:0] BOP_DEC    = 4'h3;
   localparam logic [3:0] BOP_OR     = 4'h4;
   localparam logic [3:0] BOP_AND    = 4'h5;
   localparam logic [3:0] BOP_XOR    = 4'h6;
   localparam logic [3:0] BOP_ADD    = 4'h7;
   localparam logic [3:0] BOP_MOVF   = 4'h8;
   localparam logic [3:0] BOP_COMP   = 4'h9;
   localparam logic [3:0] BOP_INC    = 4'hA;
   localparam logic [3:0] BOP_DECSK  = 4'hB;
   localparam logic [3:0] BOP_ROR    = 4'hC;
   localparam logic [3:0] BOP_ROL    = 4'hD;
   localparam logic [3:0] BOP_SWAP   = 4'hE;
   localparam logic [3:0] BOP_INCSK  = 4'hF;

   typedef enum logic [3:0] {
      OP_ZERO, OP_PASS, OP_PASS_W, OP_ADD, OP_SUB, OP_AND, OP_IOR, OP_XOR,
      OP_COM,  OP_INC,  OP_DEC,    OP_RRC, OP_RLC, OP_SWAP, OP_BCLR, OP_BSET
   } alu_op_e;

   typedef struct packed {
      alu_op_e                op;
      logic                   src_lit;
      logic                   wr_w;
      logic                   wr_file;
      logic                   upd_c;
      logic                   upd_dc;
      logic                   upd_z;
      logic                   skip_chk;
      logic [BIT_IDX_W-1:0]   bit_sel;
   } alu_ctrl_t;

endpackage

// File: rtl/byte_alu_decode.sv
module byte_alu_decode
   import byte_alu_pkg::*;
#(
   parameter int INSTR_W = 14,
   parameter int DATA_W  = 8,
   localparam int CLS_LSB = INSTR_W - 2,
   localparam int OP_LSB  = INSTR_W - 6,
   localparam int D_POS   = DATA_W - 1,
   localparam int B_LSB   = DATA_W - 1
)(
   input  logic [INSTR_W-1:0] instr,
   output alu_ctrl_t          ctl,
   output logic [DATA_W-1:0]  lit
);

   logic [1:0] cls;
   logic [3:0] opn;
   logic       dst_f;
   logic       route;

   assign cls   = instr[CLS_LSB +: 2];
   assign opn   = instr[OP_LSB +: 4];
   assign dst_f = instr[D_POS];
   assign lit   = instr[DATA_W-1:0];

   always_comb begin
      ctl         = '0;
      ctl.op      = OP_ZERO;
      ctl.bit_sel = instr[B_LSB +: BIT_IDX_W];
      route       = 1'b0;
      case (cls)
         CLS_BYTE: begin
            case (opn)
               BOP_MOVE_W: begin
                  if (dst_f) begin
                     ctl.op      = OP_PASS_W;
                     ctl.wr_file = 1'b1;
                  end
               end
               BOP_CLEAR: begin ctl.op = OP_ZERO; ctl.upd_z = 1'b1; route = 1'b1; end
               BOP_SUB: begin
                  ctl.op = OP_SUB; ctl.upd_c = 1'b1; ctl.upd_dc = 1'b1; ctl.upd_z = 1'b1;
                  route = 1'b1;
               end
               BOP_ADD: begin
                  ctl.op = OP_ADD; ctl.upd_c = 1'b1; ctl.upd_dc = 1'b1; ctl.upd_z = 1'b1;
                  route = 1'b1;
               end
               BOP_DEC:   begin ctl.op = OP_DEC;  ctl.upd_z = 1'b1; route = 1'b1; end
               BOP_OR:    begin ctl.op = OP_IOR;  ctl.upd_z = 1'b1; route = 1'b1; end
               BOP_AND:   begin ctl.op = OP_AND;  ctl.upd_z = 1'b1; route = 1'b1; end
               BOP_XOR:   begin ctl.op = OP_XOR;  ctl.upd_z = 1'b1; route = 1'b1; end
               BOP_MOVF:  begin ctl.op = OP_PASS; ctl.upd_z = 1'b1; route = 1'b1; end
               BOP_COMP:  begin ctl.op = OP_COM;  ctl.upd_z = 1'b1; route = 1'b1; end
               BOP_INC:   begin ctl.op = OP_INC;  ctl.upd_z = 1'b1; route = 1'b1; end
               BOP_DECSK: begin ctl.op = OP_DEC;  ctl.skip_chk = 1'b1; route = 1'b1; end
               BOP_INCSK: begin ctl.op = OP_INC;  ctl.skip_chk = 1'b1; route = 1'b1; end
               BOP_ROR:   begin ctl.op = OP_RRC;  ctl.upd_c = 1'b1; route = 1'b1; end
               BOP_ROL:   begin ctl.op = OP_RLC;  ctl.upd_c = 1'b1; route = 1'b1; end
               BOP_SWAP:  begin ctl.op = OP_SWAP; route = 1'b1; end
               default: ;
            endcase
            if (route) begin
               ctl.wr_w    = !dst_f;
               ctl.wr_file = dst_f;
            end
         end
         CLS_BIT: begin
            if (!opn[3]) begin
               ctl.op      = opn[2] ? OP_BSET : OP_BCLR;
               ctl.wr_file = 1'b1;
            end
         end
         CLS_LIT: begin
            ctl.src_lit = 1'b1;
            casez (opn)
               4'b00??: begin ctl.op = OP_PASS; ctl.wr_w = 1'b1; end
               4'b1000: begin ctl.op = OP_IOR;  ctl.wr_w = 1'b1; ctl.upd_z = 1'b1; end
               4'b1001: begin ctl.op = OP_AND;  ctl.wr_w = 1'b1; ctl.upd_z = 1'b1; end
               4'b1010: begin ctl.op = OP_XOR;  ctl.wr_w = 1'b1; ctl.upd_z = 1'b1; end
               4'b110?: begin
                  ctl.op = OP_SUB; ctl.wr_w = 1'b1;
                  ctl.upd_c = 1'b1; ctl.upd_dc = 1'b1; ctl.upd_z = 1'b1;
               end
               4'b111?: begin
                  ctl.op = OP_ADD; ctl.wr_w = 1'b1;
                  ctl.upd_c = 1'b1; ctl.upd_dc = 1'b1; ctl.upd_z = 1'b1;
               end
               default: ctl.src_lit = 1'b0;
            endcase
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/byte_alu_core.sv
module byte_alu_core
   import byte_alu_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter bit ADD_SPLIT = 1'b1,
   localparam int NIB_W    = DATA_W / 2,
   localparam int SEL_W    = $clog2(DATA_W)
)(
   input  alu_op_e            op,
   input  logic [DATA_W-1:0]  opnd,
   input  logic [DATA_W-1:0]  w_val,
   input  logic               c_in,
   input  logic [SEL_W-1:0]   bit_sel,
   output logic [DATA_W-1:0]  res,
   output logic               c_out,
   output logic               dc_out
);

   logic              sub_mode;
   logic [DATA_W-1:0] addend;
   logic [DATA_W-1:0] sum;
   logic              carry_hi;
   logic              carry_mid;
   logic [DATA_W-1:0] bit_mod;

   // subtraction = operand + ~W + 1, so carry means "no borrow"
   assign sub_mode = (op == OP_SUB);
   assign addend   = sub_mode ? ~w_val : w_val;

   generate
      if (ADD_SPLIT) begin : g_split
         logic [NIB_W:0] lo;
         logic [NIB_W:0] hi;
         assign lo = {1'b0, opnd[NIB_W-1:0]} + {1'b0, addend[NIB_W-1:0]}
                   + {{NIB_W{1'b0}}, sub_mode};
         assign hi = {1'b0, opnd[DATA_W-1:NIB_W]} + {1'b0, addend[DATA_W-1:NIB_W]}
                   + {{NIB_W{1'b0}}, lo[NIB_W]};
         assign sum       = {hi[NIB_W-1:0], lo[NIB_W-1:0]};
         assign carry_mid = lo[NIB_W];
         assign carry_hi  = hi[NIB_W];
      end else begin : g_flat
         logic [DATA_W:0] full;
         logic [NIB_W:0]  lo;
         assign full = {1'b0, opnd} + {1'b0, addend} + {{DATA_W{1'b0}}, sub_mode};
         assign lo   = {1'b0, opnd[NIB_W-1:0]} + {1'b0, addend[NIB_W-1:0]}
                     + {{NIB_W{1'b0}}, sub_mode};
         assign sum       = full[DATA_W-1:0];
         assign carry_mid = lo[NIB_W];
         assign carry_hi  = full[DATA_W];
      end
   endgenerate

   always_comb begin
      bit_mod          = opnd;
      bit_mod[bit_sel] = (op == OP_BSET);
   end

   always_comb begin
      case (op)
         OP_PASS:   res = opnd;
         OP_PASS_W: res = w_val;
         OP_ADD,
         OP_SUB:    res = sum;
         OP_AND:    res = opnd & w_val;
         OP_IOR:    res = opnd | w_val;
         OP_XOR:    res = opnd ^ w_val;
         OP_COM:    res = ~opnd;
         OP_INC:    res = opnd + {{(DATA_W-1){1'b0}}, 1'b1};
         OP_DEC:    res = opnd - {{(DATA_W-1){1'b0}}, 1'b1};
         OP_RRC:    res = {c_in, opnd[DATA_W-1:1]};
         OP_RLC:    res = {opnd[DATA_W-2:0], c_in};
         OP_SWAP:   res = {opnd[NIB_W-1:0], opnd[DATA_W-1:NIB_W]};
         OP_BCLR,
         OP_BSET:   res = bit_mod;
         default:   res = '0;
      endcase
   end

   always_comb begin
      case (op)
         OP_ADD, OP_SUB: c_out = carry_hi;
         OP_RRC:         c_out = opnd[0];
         OP_RLC:         c_out = opnd[DATA_W-1];
         default:        c_out = c_in;
      endcase
      dc_out = carry_mid;
   end

endmodule

// File: rtl/byte_alu_state.sv
module byte_alu_state #(
   parameter int              DATA_W = 8,
   parameter logic [DATA_W-1:0] W_RST = '0
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              exec_en,
   input  logic              wr_w,
   input  logic              upd_c,
   input  logic              upd_dc,
   input  logic              upd_z,
   input  logic [DATA_W-1:0] res,
   input  logic              c_new,
   input  logic              dc_new,
   output logic [DATA_W-1:0] w_q,
   output logic              c_q,
   output logic              dc_q,
   output logic              z_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         w_q  <= W_RST;
         c_q  <= 1'b0;
         dc_q <= 1'b0;
         z_q  <= 1'b0;
      end else if (exec_en) begin
         if (wr_w)   w_q  <= res;
         if (upd_c)  c_q  <= c_new;
         if (upd_dc) dc_q <= dc_new;
         if (upd_z)  z_q  <= (res == '0);
      end
   end

endmodule

// File: rtl/byte_alu_exec.sv
module byte_alu_exec
   import byte_alu_pkg::*;
#(
   parameter int                DATA_W    = 8,
   parameter int                INSTR_W   = 14,
   parameter bit                ADD_SPLIT = 1'b1,
   parameter logic [DATA_W-1:0] W_RST     = '0
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               exec_en,
   input  logic [INSTR_W-1:0] instr,
   input  logic [DATA_W-1:0]  freg_in,
   output logic [DATA_W-1:0]  result,
   output logic               wr_w,
   output logic               wr_file,
   output logic               skip_zero,
   output logic [DATA_W-1:0]  w_q,
   output logic               c_q,
   output logic               dc_q,
   output logic               z_q
);

   generate
      if (DATA_W != BYTE_W) begin : g_bad_data_w
         $error("byte_alu_exec: DATA_W must equal the package byte width");
      end
      if (INSTR_W != DATA_W + 6) begin : g_bad_instr_w
         $error("byte_alu_exec: INSTR_W must be DATA_W + 6");
      end
      if (DATA_W % 2 != 0) begin : g_bad_nibble
         $error("byte_alu_exec: DATA_W must be even for the nibble carry");
      end
   endgenerate

   alu_ctrl_t         ctl;
   logic [DATA_W-1:0] lit;
   logic [DATA_W-1:0] opnd;
   logic              c_new;
   logic              dc_new;

   byte_alu_decode #(.INSTR_W(INSTR_W), .DATA_W(DATA_W)) u_dec (
      .instr (instr),
      .ctl   (ctl),
      .lit   (lit)
   );

   assign opnd = ctl.src_lit ? lit : freg_in;

   byte_alu_core #(.DATA_W(DATA_W), .ADD_SPLIT(ADD_SPLIT)) u_core (
      .op      (ctl.op),
      .opnd    (opnd),
      .w_val   (w_q),
      .c_in    (c_q),
      .bit_sel (ctl.bit_sel),
      .res     (result),
      .c_out   (c_new),
      .dc_out  (dc_new)
   );

   byte_alu_state #(.DATA_W(DATA_W), .W_RST(W_RST)) u_state (
      .clk     (clk),
      .rst_n   (rst_n),
      .exec_en (exec_en),
      .wr_w    (ctl.wr_w),
      .upd_c   (ctl.upd_c),
      .upd_dc  (ctl.upd_dc),
      .upd_z   (ctl.upd_z),
      .res     (result),
      .c_new   (c_new),
      .dc_new  (dc_new),
      .w_q     (w_q),
      .c_q     (c_q),
      .dc_q    (dc_q),
      .z_q     (z_q)
   );

   assign wr_w      = ctl.wr_w;
   assign wr_file   = ctl.wr_file;
   assign skip_zero = ctl.skip_chk && (result == '0);

endmodule

// File: rtl/byte_alu_exec_chk.sv
module byte_alu_exec_chk #(
   parameter int DATA_W  = 8,
   parameter int INSTR_W = 14
)(
   input logic               clk,
   input logic               rst_n,
   input logic               exec_en,
   input logic [INSTR_W-1:0] instr,
   input logic [DATA_W-1:0]  freg_in,
   input logic [DATA_W-1:0]  result,
   input logic               wr_w,
   input logic               wr_file,
   input logic               skip_zero,
   input logic [DATA_W-1:0]  w_q,
   input logic               c_q,
   input logic               dc_q,
   input logic               z_q
);

   AST_ONE_DEST: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_w && wr_file)); // R2
   AST_W_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      exec_en && wr_w |=> w_q == $past(result)); // R2
   AST_W_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(exec_en && wr_w) |=> w_q == $past(w_q)); // R11
   AST_FLAG_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !exec_en |=> {c_q, dc_q, z_q} == $past({c_q, dc_q, z_q})); // R11
   AST_ADD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      exec_en && instr[INSTR_W-1:INSTR_W-6] == 6'b000111
      |=> z_q == ($past(result) == '0)); // R3
   AST_ROL_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
      exec_en && instr[INSTR_W-1:INSTR_W-6] == 6'b001101
      |=> c_q == $past(freg_in[DATA_W-1])); // R6
   AST_SWAP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      exec_en && instr[INSTR_W-1:INSTR_W-6] == 6'b001110
      |=> {c_q, dc_q, z_q} == $past({c_q, dc_q, z_q})); // R7
   AST_BIT_DEST: assert property (@(posedge clk) disable iff (!rst_n)
      instr[INSTR_W-1:INSTR_W-3] == 3'b010 |-> wr_file && !wr_w); // R9
   AST_SKIP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      skip_zero |-> result == '0 && instr[INSTR_W-1:INSTR_W-2] == 2'b00); // R10

endmodule

bind byte_alu_exec byte_alu_exec_chk #(.DATA_W(DATA_W), .INSTR_W(INSTR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .exec_en   (exec_en),
   .instr     (instr),
   .freg_in   (freg_in),
   .result    (result),
   .wr_w      (wr_w),
   .wr_file   (wr_file),
   .skip_zero (skip_zero),
   .w_q       (w_q),
   .c_q       (c_q),
   .dc_q      (dc_q),
   .z_q       (z_q)
);

// File: tb/sim_byte_alu_exec.sv
module sim_byte_alu_exec;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        exec_en = 1'b0;
   logic [13:0] instr = '0;
   logic [7:0]  freg_in = '0;
   logic [7:0]  result;
   logic        wr_w, wr_file, skip_zero;
   logic [7:0]  w_q;
   logic        c_q, dc_q, z_q;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   logic [7:0] m_w = 8'h00;
   logic       m_c = 1'b0, m_dc = 1'b0, m_z = 1'b0;

   typedef struct packed {
      logic [7:0] res;
      logic ww, wf, uc, udc, uz, skip, c, dc;
   } exp_t;

   always #5 clk = ~clk;

   byte_alu_exec u0 (
      .clk(clk), .rst_n(rst_n), .exec_en(exec_en), .instr(instr), .freg_in(freg_in),
      .result(result), .wr_w(wr_w), .wr_file(wr_file), .skip_zero(skip_zero),
      .w_q(w_q), .c_q(c_q), .dc_q(dc_q), .z_q(z_q)
   );

   task automatic chk(input string req, input string what, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic string req_of(input logic [13:0] ins);
      logic [3:0] o;
      o = ins[11:8];
      case (ins[13:12])
         2'b00: begin
            case (o)
               4'h0: return ins[7] ? "R7" : "R12";
               4'h1: return "R8";
               4'h2: return "R4";
               4'h7: return "R3";
               4'hB, 4'hF: return "R10";
               4'hC, 4'hD: return "R6";
               4'hE: return "R7";
               default: return "R5";
            endcase
         end
         2'b01: return o[3] ? "R12" : "R9";
         2'b11: begin
            if (o[3:2] == 2'b00) return "R7";
            if (o[3:1] == 3'b110) return "R4";
            if (o[3:1] == 3'b111) return "R3";
            if (o == 4'hB || o[3:2] == 2'b01) return "R12";
            return "R5";
         end
         default: return "R12";
      endcase
   endfunction

   function automatic exp_t model(input logic [13:0] ins, input logic [7:0] f,
                                  input logic [7:0] w, input logic c);
      exp_t e;
      logic [7:0] k;
      logic d;
      logic [2:0] b;
      e = '0;
      k = ins[7:0];
      d = ins[7];
      b = ins[9:7];
      case (ins[13:12])
         2'b00: begin
            case (ins[11:8])
               4'h0: if (d) begin e.res = w; e.wf = 1'b1; end
               4'h1: begin e.res = 8'h00; e.uz = 1'b1; end
               4'h2: begin
                  e.res = f - w; e.c = (f >= w); e.dc = (f[3:0] >= w[3:0]);
                  e.uc = 1'b1; e.udc = 1'b1; e.uz = 1'b1;
               end
               4'h7: begin
                  e.res = f + w; e.c = (int'(f) + int'(w) > 255);
                  e.dc = (int'(f[3:0]) + int'(w[3:0]) > 15);
                  e.uc = 1'b1; e.udc = 1'b1; e.uz = 1'b1;
               end
               4'h3: begin e.res = f - 8'd1; e.uz = 1'b1; end
               4'h4: begin e.res = f | w; e.uz = 1'b1; end
               4'h5: begin e.res = f & w; e.uz = 1'b1; end
               4'h6: begin e.res = f ^ w; e.uz = 1'b1; end
               4'h8: begin e.res = f; e.uz = 1'b1; end
               4'h9: begin e.res = ~f; e.uz = 1'b1; end
               4'hA: begin e.res = f + 8'd1; e.uz = 1'b1; end
               4'hB: begin e.res = f - 8'd1; e.skip = (f == 8'd1); end
               4'hF: begin e.res = f + 8'd1; e.skip = (f == 8'hFF); end
               4'hC: begin e.res = {c, f[7:1]}; e.c = f[0]; e.uc = 1'b1; end
               4'hD: begin e.res = {f[6:0], c}; e.c = f[7]; e.uc = 1'b1; end
               default: e.res = {f[3:0], f[7:4]};
            endcase
            if (ins[11:8] != 4'h0) begin e.ww = !d; e.wf = d; end
         end
         2'b01: begin
            if (!ins[11]) begin
               e.res = f;
               e.res[b] = ins[10];
               e.wf = 1'b1;
            end
         end
         2'b11: begin
            e.ww = 1'b1;
            casez (ins[11:8])
               4'b00??: e.res = k;
               4'b1000: begin e.res = k | w; e.uz = 1'b1; end
               4'b1001: begin e.res = k & w; e.uz = 1'b1; end
               4'b1010: begin e.res = k ^ w; e.uz = 1'b1; end
               4'b110?: begin
                  e.res = k - w; e.c = (k >= w); e.dc = (k[3:0] >= w[3:0]);
                  e.uc = 1'b1; e.udc = 1'b1; e.uz = 1'b1;
               end
               4'b111?: begin
                  e.res = k + w; e.c = (int'(k) + int'(w) > 255);
                  e.dc = (int'(k[3:0]) + int'(w[3:0]) > 15);
                  e.uc = 1'b1; e.udc = 1'b1; e.uz = 1'b1;
               end
               default: e.ww = 1'b0;
            endcase
         end
         default: ;
      endcase
      return e;
   endfunction

   task automatic run_op(input logic [13:0] ins, input logic [7:0] fv, input logic ex);
      exp_t  e;
      string rq;
      @(negedge clk);
      instr   = ins;
      freg_in = fv;
      exec_en = ex;
      #1;
      e  = model(ins, fv, m_w, m_c);
      rq = req_of(ins);
      if (e.ww || e.wf) chk(rq, "result", 32'(result), 32'(e.res));
      chk(rq, "wr_w", 32'(wr_w), 32'(e.ww));
      chk(rq, "wr_file", 32'(wr_file), 32'(e.wf));
      chk(rq, "skip_zero", 32'(skip_zero), 32'(e.skip));
      @(posedge clk);
      #1;
      if (ex) begin
         if (e.ww)  m_w  = e.res;
         if (e.uc)  m_c  = e.c;
         if (e.udc) m_dc = e.dc;
         if (e.uz)  m_z  = (e.res == 8'h00);
      end else begin
         rq = "R11";
      end
      chk(rq, "w_q", 32'(w_q), 32'(m_w));
      chk(rq, "c_q", 32'(c_q), 32'(m_c));
      chk(rq, "dc_q", 32'(dc_q), 32'(m_dc));
      chk(rq, "z_q", 32'(z_q), 32'(m_z));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_err++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h0000_5A17));
      repeat (3) @(posedge clk);
      #1;
      // R1: reset values while reset is held
      chk("R1", "w_q", 32'(w_q), 32'h00);
      chk("R1", "flags", 32'({c_q, dc_q, z_q}), 32'h0);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      chk("R1", "w_q after release", 32'(w_q), 32'h00);

      run_op(14'h300F, 8'h00, 1'b1);   // MOVLW 0x0F                R7
      run_op(14'h0700, 8'h01, 1'b1);   // ADDWF d=0: 0x10, DC=1     R3
      run_op(14'h3001, 8'h00, 1'b1);   // MOVLW 1
      run_op(14'h3EFF, 8'h00, 1'b1);   // ADDLW 0xFF: 0, C DC Z     R3
      run_op(14'h3005, 8'h00, 1'b1);   // MOVLW 5
      run_op(14'h3C05, 8'h00, 1'b1);   // SUBLW 5-5: 0, C=1, Z=1    R4
      run_op(14'h3005, 8'h00, 1'b1);
      run_op(14'h0280, 8'h03, 1'b1);   // SUBWF d=1: 3-5 borrow     R4 R2
      run_op(14'h3C03, 8'h00, 1'b1);   // SUBLW 3-5 into W          R4
      run_op(14'h0D00, 8'h80, 1'b1);   // RLF d=0: C in, C=1        R6
      run_op(14'h0C80, 8'h01, 1'b1);   // RRF d=1: carry loop       R6
      run_op(14'h0100, 8'h55, 1'b1);   // CLRW                       R8
      run_op(14'h0180, 8'h55, 1'b1);   // CLRF                       R8
      run_op(14'h30AA, 8'h00, 1'b0);   // strobe low, W held         R11
      run_op(14'h1780, 8'h00, 1'b1);   // BSF bit 7                  R9
      run_op(14'h1000, 8'hFF, 1'b1);   // BCF bit 0                  R9
      run_op(14'h0F00, 8'hFF, 1'b1);   // INCFSZ wraps to zero       R10
      run_op(14'h0B80, 8'h02, 1'b1);   // DECFSZ non-zero            R10
      run_op(14'h0B00, 8'h01, 1'b1);   // DECFSZ to zero             R10
      run_op(14'h0E00, 8'hA5, 1'b1);   // SWAPF                      R7
      run_op(14'h3077, 8'h00, 1'b1);
      run_op(14'h0080, 8'h00, 1'b1);   // MOVWF                      R7
      run_op(14'h0900, 8'hFF, 1'b1);   // COMF to zero               R5
      run_op(14'h3955, 8'h00, 1'b1);   // ANDLW                      R5
      run_op(14'h2000, 8'h12, 1'b1);   // class 10                   R12
      run_op(14'h1C00, 8'h12, 1'b1);   // bit test                   R12
      run_op(14'h3400, 8'h12, 1'b1);   // 11 01xx                    R12
      run_op(14'h3B00, 8'h12, 1'b1);   // 11 1011                    R12
      run_op(14'h0000, 8'h12, 1'b1);   // 00 0000 d=0                R12

      for (int i = 0; i < 1500; i++) begin
         logic [13:0] ri;
         logic [7:0]  rf;
         logic        re;
         ri = 14'($urandom());
         rf = 8'($urandom());
         if (i % 7 == 0) rf = 8'hFF;
         if (i % 11 == 0) rf = 8'h00;
         re = ($urandom_range(0, 9) < 8);
         run_op(ri, rf, re);
      end

      @(negedge clk);
      exec_en = 1'b0;
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule